// File: doc/BRIEF.md
# Bit Error Rate Tester

This block generates a test bit stream and checks a returned stream for bit errors. It serves a serial payload path in which every bit is qualified by a clock enable. One of four patterns can be selected: a 2^15-1 pseudorandom sequence, a quasi-random signal source (a 2^20-1 sequence with long zero runs suppressed), a user word of programmable length, or a fixed word with long runs of ones and zeros. The transmit side can invert one chosen bit, or invert bits continuously at a decimal rate, either without end or up to a set number of errors.

The receive side needs no seed and no alignment. It learns the pattern phase from the incoming bits. Once it has seen 32 bits in a row that follow the pattern, it declares sync. From then on it predicts each bit from its own free-running reference, so one line error counts once. Too many errors drop sync and restart the search. While in sync, the block counts received bits and errored bits. A latch strobe copies both counts to the outputs and clears the running counters.

Top module: `bert_engine`

## Requirements
- R1: `cfg_pat` selects the pattern: 0 = PRBS15, 1 = QRSS, 2 = user word, 3 = fixed word. The generator moves one bit forward on each cycle with `tx_en` high, and `tx_bit` holds its value while `tx_en` is low.
- R2: PRBS15: each bit is the XOR of the bits sent 15 and 14 positions before it. After a restart, the history is all ones.
- R3: QRSS: a hidden sequence follows b(n) = b(n-20) XOR b(n-17), and its history is all ones after a restart. The bit sent is b(n), forced to 1 when the previous 14 hidden bits are all zero. The output never holds more than 14 zeros in a row.
- R4: User word: the bits sent are `cfg_word` bit 0, bit 1, and so on up to bit L-1, then repeat. L is `cfg_len`; a value of 0 or above 32 means 32.
- R5: Fixed word: the bits of 32'hFE000381 are sent from bit 0 up to bit 31, and the word repeats.
- R6: Any change of `cfg_pat`, `cfg_len` or `cfg_word` restarts the generator from its initial state and drops the checker out of sync.
- R7: A high level on `err_one` during a cycle with `tx_en` low inverts exactly the next enabled transmit bit, and only that bit.
- R8: While `err_cont` is high, every P-th enabled bit is inverted, counting from when `err_cont` rose. P = 10^n, where n is `err_rate` (1..7) and code 0 acts as 1.
- R9: When `err_limit` is nonzero, continuous insertion stops after `err_limit` inverted bits. A zero value means no limit.
- R10: `in_sync` rises after 32 consecutive received bits that match the prediction. It falls on the 6th error within a 64-bit block (blocks are counted from sync), and the checker then reseeds from the received stream.
- R11: Only bits that arrive while in sync are counted. Each one adds to the bit count, and each mismatch also adds to the error count.
- R12: `cnt_latch` copies the running counts to `bit_count` and `err_count` and clears them. The counts saturate at 2^CNT_W-1 and read 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_pat | input | 2 | Pattern select |
| cfg_len | input | 6 | User word length |
| cfg_word | input | 32 | User word, bit 0 first |
| tx_en | input | 1 | Transmit bit enable |
| tx_bit | output | 1 | Transmit bit |
| err_one | input | 1 | Single error request |
| err_cont | input | 1 | Continuous error enable |
| err_rate | input | 3 | Error rate exponent |
| err_limit | input | LIM_W | Continuous error limit, 0 = none |
| rx_en | input | 1 | Receive bit enable |
| rx_bit | input | 1 | Receive bit |
| cnt_latch | input | 1 | Latch and clear the counters |
| in_sync | output | 1 | Checker in sync |
| bit_count | output | CNT_W | Latched bit count |
| err_count | output | CNT_W | Latched error count |

## Verification
The hardest conditions to reach from the ports are counter saturation and loss of sync followed by a fresh reseed. The bench reaches saturation by using a narrow counter width and running a long slow-rate insertion. It forces loss with a continuous rate of one error in ten bits, then drops the insertion and watches the checker find the phase again without help. A sweep over every user length from 1 to 32 checks both the generated sequence and sync entry, including that sync is still absent 20 bits after each restart.

// File: rtl/bert_pkg.sv
package bert_pkg;

  typedef enum logic [1:0] {
    PAT_PRBS15 = 2'd0,
    PAT_QRSS   = 2'd1,
    PAT_USER   = 2'd2,
    PAT_FIXED  = 2'd3
  } pat_e;

  localparam int unsigned ST_W     = 32;            // history register width
  localparam int unsigned MAX_LEN  = 32;            // longest repeating word
  localparam int unsigned LEN_W    = 6;
  localparam int unsigned P15_A    = 14;            // taps of x^15+x^14+1
  localparam int unsigned P15_B    = 13;
  localparam int unsigned Q20_A    = 19;            // taps of x^20+x^17+1
  localparam int unsigned Q20_B    = 16;
  localparam int unsigned ZRUN     = 14;            // longest zero run allowed
  localparam logic [ST_W-1:0] FIXED_WORD = 32'hFE00_0381;

  function automatic logic [LEN_W-1:0] eff_len(input logic [LEN_W-1:0] len);
    if (len == '0 || len > LEN_W'(MAX_LEN)) return LEN_W'(MAX_LEN);
    return len;
  endfunction

  // next raw sequence bit from a history (bit 0 = newest)
  function automatic logic seq_bit(input pat_e p, input logic [ST_W-1:0] st,
                                   input logic [LEN_W-1:0] len);
    logic [4:0] idx;
    idx = 5'(len - 1'b1);
    case (p)
      PAT_PRBS15: return st[P15_A] ^ st[P15_B];
      PAT_QRSS:   return st[Q20_A] ^ st[Q20_B];
      default:    return st[idx];
    endcase
  endfunction

  function automatic logic force_one(input pat_e p, input logic [ST_W-1:0] st);
    return (p == PAT_QRSS) && (st[ZRUN-1:0] == '0);
  endfunction

endpackage

// File: rtl/bert_gen.sv
module bert_gen
  import bert_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  pat_e             pat,
  input  logic [LEN_W-1:0] len,
  input  logic [ST_W-1:0]  word,
  input  logic             adv,
  output logic             pat_bit
);

  logic [ST_W-1:0] st_q, st_d, seed;
  logic            nxt;

  always_comb begin
    for (int k = 0; k < ST_W; k++) begin
      if (pat == PAT_PRBS15 || pat == PAT_QRSS) seed[k] = 1'b1;
      else if (k < int'(len))                   seed[k] = word[5'(int'(len) - 1 - k)];
      else                                      seed[k] = 1'b0;
    end
  end

  always_comb begin
    nxt     = seq_bit(pat, st_q, len);
    pat_bit = nxt | force_one(pat, st_q);
    st_d    = st_q;
    if (restart)  st_d = seed;
    else if (adv) st_d = {st_q[ST_W-2:0], nxt};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '1;
    else        st_q <= st_d;
  end

  // R2: the short sequence never reaches its all-zero lock-up state
  a_r2_lfsr_alive: assert property (@(posedge clk) disable iff (!rst_n)
    (pat == PAT_PRBS15 && !restart) |-> (st_q[P15_A:0] != '0));
  // R3: same for the long sequence behind the suppressed stream
  a_r3_lfsr_alive: assert property (@(posedge clk) disable iff (!rst_n)
    (pat == PAT_QRSS && !restart) |-> (st_q[Q20_A:0] != '0));

endmodule

// File: rtl/bert_inject.sv
module bert_inject #(
  parameter int unsigned RATE_CW = 24,
  parameter int unsigned LIM_W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             one,
  input  logic             cont,
  input  logic [2:0]       rate,
  input  logic [LIM_W-1:0] limit,
  output logic             flip
);

  logic               pend_q, pend_d;
  logic [RATE_CW-1:0] cnt_q, cnt_d, period;
  logic [LIM_W-1:0]   ninj_q, ninj_d;
  logic               lim_hit, fire_c;

  function automatic logic [RATE_CW-1:0] rate_period(input logic [2:0] code);
    logic [RATE_CW-1:0] p;
    p = RATE_CW'(10);
    for (int i = 2; i <= 7; i++)
      if (int'(code) >= i) p = p * RATE_CW'(10);
    return p;
  endfunction

  always_comb begin
    period  = rate_period(rate);
    lim_hit = (limit != '0) && (ninj_q >= limit);
    fire_c  = cont && !lim_hit && (cnt_q == period - 1'b1);
    flip    = pend_q | fire_c;

    pend_d = pend_q;
    if (adv) pend_d = 1'b0;
    if (one) pend_d = 1'b1;

    cnt_d = cnt_q;
    if (!cont)    cnt_d = '0;
    else if (adv) cnt_d = (cnt_q >= period - 1'b1) ? '0 : cnt_q + 1'b1;

    ninj_d = ninj_q;
    if (!cont)                                  ninj_d = '0;
    else if (adv && fire_c && ninj_q != '1)     ninj_d = ninj_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      cnt_q  <= '0;
      ninj_q <= '0;
    end else begin
      pend_q <= pend_d;
      cnt_q  <= cnt_d;
      ninj_q <= ninj_d;
    end
  end

  // R7: a pending single error is used up by the bit it lands on
  a_r7_single_consumed: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && adv && !one) |=> !pend_q);
  // R8: after a bit with a steady rate the spacing counter stays below the period
  a_r8_spacing_range: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(adv) && $past(cont) && cont && $stable(rate)) |-> (cnt_q < period));
  // R9: at the cap no continuous inversion reaches the stream
  a_r9_cap_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (cont && limit != '0 && ninj_q >= limit && !pend_q) |-> !flip);

endmodule

// File: rtl/bert_tally.sv
module bert_tally #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_bit,
  input  logic             inc_err,
  input  logic             latch,
  output logic [CNT_W-1:0] bit_count,
  output logic [CNT_W-1:0] err_count
);

  localparam logic [CNT_W-1:0] CMAX = '1;

  logic [CNT_W-1:0] rb_q, rb_d, re_q, re_d, sb_q, sb_d, se_q, se_d;

  always_comb begin
    sb_d = sb_q;
    se_d = se_q;
    if (latch) begin
      sb_d = rb_q;
      se_d = re_q;
      rb_d = CNT_W'(inc_bit);
      re_d = CNT_W'(inc_err);
    end else begin
      rb_d = (inc_bit && rb_q != CMAX) ? rb_q + 1'b1 : rb_q;
      re_d = (inc_err && re_q != CMAX) ? re_q + 1'b1 : re_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rb_q <= '0;
      re_q <= '0;
      sb_q <= '0;
      se_q <= '0;
    end else begin
      rb_q <= rb_d;
      re_q <= re_d;
      sb_q <= sb_d;
      se_q <= se_d;
    end
  end

  assign bit_count = sb_q;
  assign err_count = se_q;

  // R11: errors are only counted alongside bits, so they never lead
  a_r11_err_not_above_bits: assert property (@(posedge clk) disable iff (!rst_n)
    re_q <= rb_q);
  // R12: a full counter stays full until latched
  a_r12_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (rb_q == CMAX && !latch) |=> (rb_q == CMAX));
  // R12: latching restarts the running count
  a_r12_latch_clears: assert property (@(posedge clk) disable iff (!rst_n)
    latch |=> (rb_q <= CNT_W'(1)));

endmodule

// File: rtl/bert_check.sv
module bert_check
  import bert_pkg::*;
#(
  parameter int unsigned SYNC_RUN = 32,
  parameter int unsigned LOSS_WIN = 64,
  parameter int unsigned LOSS_ERR = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  pat_e             pat,
  input  logic [LEN_W-1:0] len,
  input  logic             adv,
  input  logic             rx_bit,
  output logic             locked,
  output logic             cnt_bit,
  output logic             cnt_err
);

  localparam int unsigned RUN_W  = $clog2(SYNC_RUN + 1);
  localparam int unsigned WIN_W  = $clog2(LOSS_WIN);
  localparam int unsigned LERR_W = $clog2(LOSS_ERR + 1);

  logic [ST_W-1:0]   ref_q, ref_d;
  logic [RUN_W-1:0]  run_q, run_d;
  logic [WIN_W-1:0]  win_q, win_d;
  logic [LERR_W-1:0] nerr_q, nerr_d, nerr_new;
  logic              lock_q, lock_d;
  logic              exp_seq, exp_bit, miss;

  always_comb begin
    exp_seq  = seq_bit(pat, ref_q, len);
    exp_bit  = exp_seq | force_one(pat, ref_q);
    miss     = rx_bit != exp_bit;
    nerr_new = nerr_q + LERR_W'(miss);

    ref_d  = ref_q;
    run_d  = run_q;
    win_d  = win_q;
    nerr_d = nerr_q;
    lock_d = lock_q;

    if (adv) ref_d = {ref_q[ST_W-2:0], lock_q ? exp_seq : rx_bit};

    if (restart) begin
      lock_d = 1'b0;
      run_d  = '0;
    end else if (adv && !lock_q) begin
      if (miss) run_d = '0;
      else if (run_q == RUN_W'(SYNC_RUN - 1)) begin
        lock_d = 1'b1;
        run_d  = '0;
        win_d  = '0;
        nerr_d = '0;
      end else run_d = run_q + 1'b1;
    end else if (adv) begin
      if (nerr_new >= LERR_W'(LOSS_ERR)) begin
        lock_d = 1'b0;
        run_d  = '0;
      end else if (win_q == WIN_W'(LOSS_WIN - 1)) begin
        win_d  = '0;
        nerr_d = '0;
      end else begin
        win_d  = win_q + 1'b1;
        nerr_d = nerr_new;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q  <= '0;
      run_q  <= '0;
      win_q  <= '0;
      nerr_q <= '0;
      lock_q <= 1'b0;
    end else begin
      ref_q  <= ref_d;
      run_q  <= run_d;
      win_q  <= win_d;
      nerr_q <= nerr_d;
      lock_q <= lock_d;
    end
  end

  assign locked  = lock_q;
  assign cnt_bit = adv && lock_q;
  assign cnt_err = adv && lock_q && miss;

  // R10: sync is entered only on the last matching bit of a full run
  a_r10_sync_after_run: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_q) |-> ($past(adv) && !$past(miss) && $past(run_q) == RUN_W'(SYNC_RUN - 1)));
  // R10: sync is left only by a restart or the error that completes the block limit
  a_r10_loss_by_errors: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(lock_q) && !$past(restart)) |->
      ($past(adv) && $past(miss) && $past(nerr_q) == LERR_W'(LOSS_ERR - 1)));
  // R6: a restart always leaves the checker hunting
  a_r6_restart_hunts: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !lock_q);

endmodule

// File: rtl/bert_engine.sv
module bert_engine
  import bert_pkg::*;
#(
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned LIM_W   = 16,
  parameter int unsigned RATE_CW = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cfg_pat,
  input  logic [5:0]       cfg_len,
  input  logic [31:0]      cfg_word,
  input  logic             tx_en,
  output logic             tx_bit,
  input  logic             err_one,
  input  logic             err_cont,
  input  logic [2:0]       err_rate,
  input  logic [LIM_W-1:0] err_limit,
  input  logic             rx_en,
  input  logic             rx_bit,
  input  logic             cnt_latch,
  output logic             in_sync,
  output logic [CNT_W-1:0] bit_count,
  output logic [CNT_W-1:0] err_count
);

  localparam int unsigned CFG_W = 2 + LEN_W + ST_W;

  logic [1:0]       rs_q;
  logic             rst_i_n;
  logic [CFG_W-1:0] cfg_now, cfg_q;
  logic             seen_q, restart;
  pat_e             pat;
  logic [LEN_W-1:0] len_e;
  logic [ST_W-1:0]  word_e;
  logic             pat_bit, flip, cnt_bit, cnt_err;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  assign cfg_now = {cfg_pat, cfg_len, cfg_word};

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      cfg_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      cfg_q  <= cfg_now;
      seen_q <= 1'b1;
    end
  end

  always_comb begin
    restart = !seen_q || (cfg_now != cfg_q);
    pat     = pat_e'(cfg_pat);
    len_e   = (pat == PAT_FIXED) ? LEN_W'(MAX_LEN) : eff_len(cfg_len);
    word_e  = (pat == PAT_FIXED) ? FIXED_WORD : cfg_word;
  end

  bert_gen u_gen (
    .clk(clk), .rst_n(rst_i_n), .restart(restart), .pat(pat),
    .len(len_e), .word(word_e), .adv(tx_en), .pat_bit(pat_bit)
  );

  bert_inject #(.RATE_CW(RATE_CW), .LIM_W(LIM_W)) u_inj (
    .clk(clk), .rst_n(rst_i_n), .adv(tx_en), .one(err_one), .cont(err_cont),
    .rate(err_rate), .limit(err_limit), .flip(flip)
  );

  assign tx_bit = pat_bit ^ flip;

  bert_check u_chk (
    .clk(clk), .rst_n(rst_i_n), .restart(restart), .pat(pat), .len(len_e),
    .adv(rx_en), .rx_bit(rx_bit), .locked(in_sync),
    .cnt_bit(cnt_bit), .cnt_err(cnt_err)
  );

  bert_tally #(.CNT_W(CNT_W)) u_tally (
    .clk(clk), .rst_n(rst_i_n), .inc_bit(cnt_bit), .inc_err(cnt_err),
    .latch(cnt_latch), .bit_count(bit_count), .err_count(err_count)
  );

endmodule

// File: tb/sim_bert_engine.sv
module sim_bert_engine;

  localparam int CW = 10;
  localparam int LW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [1:0]    cfg_pat;
  logic [5:0]    cfg_len;
  logic [31:0]   cfg_word;
  logic          tx_en, tx_bit, err_one, err_cont;
  logic [2:0]    err_rate;
  logic [LW-1:0] err_limit;
  logic          rx_en, rx_bit, flip_rx, cnt_latch, in_sync;
  logic [CW-1:0] bit_count, err_count;

  always #5 clk = ~clk;

  assign rx_en  = tx_en;
  assign rx_bit = tx_bit ^ flip_rx;

  bert_engine #(.CNT_W(CW), .LIM_W(LW)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_pat(cfg_pat), .cfg_len(cfg_len),
    .cfg_word(cfg_word), .tx_en(tx_en), .tx_bit(tx_bit), .err_one(err_one),
    .err_cont(err_cont), .err_rate(err_rate), .err_limit(err_limit),
    .rx_en(rx_en), .rx_bit(rx_bit), .cnt_latch(cnt_latch), .in_sync(in_sync),
    .bit_count(bit_count), .err_count(err_count)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // reference pattern model, built from the requirement formulas
  int          m_pat;
  logic [63:0] m_hist;
  int          m_idx, m_len;
  logic [31:0] m_word;
  int          zr, zmax;

  task automatic check(input string tag, input longint got, input longint exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
    end
  endtask

  function automatic logic model_next();
    logic b, o;
    if (m_pat == 0) begin
      b = m_hist[14] ^ m_hist[13];
      o = b;
      m_hist = {m_hist[62:0], b};
    end else if (m_pat == 1) begin
      b = m_hist[19] ^ m_hist[16];
      o = b | (m_hist[13:0] == 14'd0);
      m_hist = {m_hist[62:0], b};
    end else begin
      o = m_word[m_idx];
      m_idx = (m_idx + 1) % m_len;
    end
    return o;
  endfunction

  task automatic set_cfg(input int p, input int len, input logic [31:0] w);
    @(negedge clk);
    tx_en = 1'b0;
    cfg_pat = 2'(p); cfg_len = 6'(len); cfg_word = w;
    m_pat = p; m_hist = '1; m_idx = 0;
    m_len = (p == 3) ? 32 : ((len == 0 || len > 32) ? 32 : len);
    m_word = (p == 3) ? 32'hFE00_0381 : w;
    zr = 0; zmax = 0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run_bits(input int n, input int gap, input int fa, input int fb,
                          input int fc, output int mism);
    logic e;
    mism = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tx_en = 1'b1;
      flip_rx = (i == fa || i == fb || i == fc);
      e = model_next();
      if (tx_bit !== e) mism++;
      if (tx_bit == 1'b0) begin zr++; if (zr > zmax) zmax = zr; end
      else zr = 0;
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        tx_en = 1'b0; flip_rx = 1'b0;
      end
    end
    @(negedge clk);
    tx_en = 1'b0; flip_rx = 1'b0;
  endtask

  task automatic do_latch();
    @(negedge clk);
    cnt_latch = 1'b1;
    @(negedge clk);
    cnt_latch = 1'b0;
  endtask

  task automatic set_err(input logic c, input int rate, input int lim);
    @(negedge clk);
    tx_en = 1'b0;
    err_cont = c; err_rate = 3'(rate); err_limit = LW'(lim);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int m, m2;
    logic held;
    rst_n = 1'b0;
    cfg_pat = 2'd0; cfg_len = 6'd0; cfg_word = '0;
    tx_en = 1'b0; err_one = 1'b0; err_cont = 1'b0; err_rate = 3'd1;
    err_limit = '0; flip_rx = 1'b0; cnt_latch = 1'b0;
    m_pat = 0; m_hist = '1; m_idx = 0; m_len = 32; m_word = '0; zr = 0; zmax = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R12 / R10: reset state
    check("R12 reset bit_count", bit_count, 0);
    check("R12 reset err_count", err_count, 0);
    check("R10 reset in_sync", in_sync, 0);

    // R4 / R10: sweep every user length
    for (int L = 1; L <= 32; L++) begin
      set_cfg(2, L, 32'h9E37_79B9 * L);
      run_bits(20, 1, -1, -1, -1, m);
      check($sformatf("R10 no sync 20 bits after restart L=%0d", L), in_sync, 0);
      run_bits(2 * L + 30, 1, -1, -1, -1, m2);
      check($sformatf("R4 user sequence L=%0d", L), m + m2, 0);
      check($sformatf("R10 sync on user word L=%0d", L), in_sync, 1);
    end
    set_cfg(2, 0, 32'h1234_5AC7);
    run_bits(80, 1, -1, -1, -1, m);
    check("R4 length 0 acts as 32", m, 0);

    // R5: fixed word
    set_cfg(3, 5, 32'h0);
    run_bits(96, 1, -1, -1, -1, m);
    check("R5 fixed word sequence", m, 0);
    check("R10 sync on fixed word", in_sync, 1);

    // R2 / R10: PRBS15
    set_cfg(0, 0, 32'h0);
    run_bits(300, 1, -1, -1, -1, m);
    check("R2 PRBS15 sequence", m, 0);
    check("R10 sync on PRBS15", in_sync, 1);

    // R1: output holds with enable low, no bit skipped
    @(negedge clk); held = tx_bit;
    repeat (5) @(negedge clk);
    check("R1 tx_bit holds while idle", tx_bit, held);
    run_bits(40, 0, -1, -1, -1, m);
    check("R1 sequence resumes after idle", m, 0);

    // R11 / R12: clean count
    do_latch();
    run_bits(500, 1, -1, -1, -1, m);
    do_latch();
    check("R11 clean bit count", bit_count, 500);
    check("R11 clean err count", err_count, 0);

    // R7: single error
    @(negedge clk); err_one = 1'b1;
    @(negedge clk); err_one = 1'b0;
    run_bits(100, 1, -1, -1, -1, m);
    do_latch();
    check("R7 single error on tx", m, 1);
    check("R7 single error counted", err_count, 1);
    check("R11 bits with single error", bit_count, 100);

    // R11: receive-side errors count once each
    run_bits(300, 0, 10, 100, 200, m);
    do_latch();
    check("R11 rx flips counted", err_count, 3);
    check("R11 bits with rx flips", bit_count, 300);

    // R9: limited continuous insertion
    set_err(1'b1, 1, 5);
    run_bits(300, 0, -1, -1, -1, m);
    set_err(1'b0, 1, 0);
    do_latch();
    check("R9 limited tx errors", m, 5);
    check("R9 limited errors counted", err_count, 5);
    check("R10 sync kept under 5 errors", in_sync, 1);

    // R8: rate 1 in 100
    set_err(1'b1, 2, 0);
    run_bits(450, 0, -1, -1, -1, m);
    set_err(1'b0, 1, 0);
    do_latch();
    check("R8 rate 100 tx errors", m, 4);
    check("R8 rate 100 counted", err_count, 4);

    // R8 / R12: rate 1 in 1000 with saturating bit count
    set_err(1'b1, 3, 0);
    run_bits(2500, 0, -1, -1, -1, m);
    set_err(1'b0, 1, 0);
    do_latch();
    check("R8 rate 1000 tx errors", m, 2);
    check("R8 rate 1000 counted", err_count, 2);
    check("R12 bit count saturates", bit_count, (1 << CW) - 1);

    // R8: code 0 acts as 1 in 10
    set_err(1'b1, 0, 0);
    run_bits(55, 0, -1, -1, -1, m);
    set_err(1'b0, 1, 0);
    do_latch();
    check("R8 code 0 tx errors", m, 5);
    check("R8 code 0 counted", err_count, 5);

    // R10: loss of sync and reseed
    set_err(1'b1, 1, 0);
    run_bits(200, 0, -1, -1, -1, m);
    set_err(1'b0, 1, 0);
    check("R8 rate 10 tx errors", m, 20);
    check("R10 sync lost under dense errors", in_sync, 0);
    run_bits(150, 0, -1, -1, -1, m);
    check("R10 reseed regains sync", in_sync, 1);

    // R6: configuration change restarts both sides
    set_cfg(0, 0, 32'h0000_0001);
    check("R6 restart drops sync", in_sync, 0);
    run_bits(100, 0, -1, -1, -1, m);
    check("R6 generator restarted from seed", m, 0);
    check("R6 resync after restart", in_sync, 1);

    // R3: QRSS
    set_cfg(1, 0, 32'h0);
    do_latch();
    run_bits(40000, 0, -1, -1, -1, m);
    do_latch();
    check("R3 QRSS sequence", m, 0);
    check("R3 QRSS zero run limit", (zmax <= 14) ? 1 : 0, 1);
    check("R3 QRSS in sync", in_sync, 1);
    check("R3 QRSS no errors counted", err_count, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule